// File: doc/BRIEF.md
# Three-valued logic operator unit

This unit evaluates one operator of a three-valued algebra per clock. Each operand and the result take one of three values: logic 0, logic 1, or N, which stands for "no communication took place on this channel". N is a real value and not a don't-care. Each value is carried on two wires, a valid bit and a data bit. Valid=0 means N, and valid=1 with data 0 or 1 means logic 0 or logic 1.

Two operands A and B and a 3-bit operator code are presented together. The result appears on the output pair after one clock edge. The operators are AND, OR, NOT, equivalence, a conditional RECEIVE and a conditional SEND. For RECEIVE and SEND, operand A is the enable channel and operand B is the data channel. The result is always in canonical form, with data at 0 whenever valid is 0. An input pair with valid=0 and data=1 is read as N.

Operator codes: 0 AND, 1 OR, 2 NOT, 3 equivalence, 4 RECEIVE, 5 SEND, 6 and 7 unused.

Top module: `tvl_op_unit`

## Requirements
- R1: While rst_n is low, and after it goes low, the output is N (y_v_o=0, y_d_o=0).
- R2: The result for the inputs present at a rising clock edge appears on the outputs after that edge. Before that edge the outputs keep the previous result.
- R3: AND (code 0) gives the Boolean AND when both operands are 0 or 1. It gives N when either operand is N.
- R4: OR (code 1) gives the Boolean OR when both operands are 0 or 1. It gives N when either operand is N.
- R5: NOT (code 2) inverts operand A when it is 0 or 1 and gives N when A is N. Operand B has no effect, whatever its encoding.
- R6: Equivalence (code 3) is never N. It gives 1 exactly when both operands hold the same value, with N equal to N, and 0 otherwise.
- R7: RECEIVE (code 4) gives 0 when enable A is 0, gives operand B when A is 1, and gives N when A is N.
- R8: SEND (code 5) gives operand B when enable A is 1, and gives N when A is 0 or N.
- R9: Codes 6 and 7 give N for every operand value.
- R10: The output is canonical: when y_v_o is 0, y_d_o is 0.
- R11: An input pair with valid=0 and data=1 behaves exactly like N (valid=0, data=0) for every operator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operator code |
| a_v_i | input | 1 | Operand A valid (enable channel for RECEIVE/SEND) |
| a_d_i | input | 1 | Operand A data |
| b_v_i | input | 1 | Operand B valid (data channel for RECEIVE/SEND) |
| b_d_i | input | 1 | Operand B data |
| y_v_o | output | 1 | Result valid |
| y_d_o | output | 1 | Result data |

## Verification
Two functions can act in the same cycle: the input cleanup that turns an ill-formed pair into N, and an operator that would otherwise pass a data bit straight through. This case arises when RECEIVE or SEND has its enable at 1 and the data channel at valid=0, data=1. It also arises when OR or AND meets such a pair next to a logic 1. The bench drives these combinations and requires the result to be N with data 0, never a stray 1. Equivalence must treat the ill-formed pair as equal to a clean N. It also switches the operator on every cycle and checks that each result lands one edge after its inputs and that the previous result holds until then.

// File: rtl/tvl_pkg.sv
package tvl_pkg;

    localparam int OP_W = 3;

    typedef struct packed {
        logic v;
        logic d;
    } tv_t;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_NOT  = 3'd2,
        OP_EQV  = 3'd3,
        OP_RECV = 3'd4,
        OP_SEND = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    localparam tv_t TV_N = '{v: 1'b0, d: 1'b0};

    typedef struct packed {
        tv_t y;
    } unit_state_t;

endpackage

// File: rtl/tvl_canon.sv
module tvl_canon
    import tvl_pkg::*;
(
    input  logic raw_v_i,
    input  logic raw_d_i,
    output tv_t  val_o
);
    always_comb begin
        val_o.v = raw_v_i;
        val_o.d = raw_v_i & raw_d_i;
    end

    always_comb begin
        a_r11_canon_clean: assert (val_o.v || !val_o.d);
    end
endmodule

// File: rtl/tvl_eval.sv
module tvl_eval
    import tvl_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  tv_t             a_i,
    input  tv_t             b_i,
    output tv_t             y_o
);
    tv_t and_r, or_r, not_r, eqv_r, recv_r, send_r;

    always_comb begin
        and_r.v  = a_i.v & b_i.v;
        and_r.d  = and_r.v & a_i.d & b_i.d;

        or_r.v   = a_i.v & b_i.v;
        or_r.d   = or_r.v & (a_i.d | b_i.d);

        not_r.v  = a_i.v;
        not_r.d  = not_r.v & ~a_i.d;

        eqv_r.v  = 1'b1;
        eqv_r.d  = (a_i.v == b_i.v) && (a_i.d == b_i.d);

        recv_r.v = (a_i.v & ~a_i.d) | (b_i.v & a_i.v & a_i.d);
        recv_r.d = recv_r.v & b_i.d & a_i.d;

        send_r.v = b_i.v & a_i.v & a_i.d;
        send_r.d = send_r.v & b_i.d;
    end

    always_comb begin
        unique case (op_e'(op_i))
            OP_AND:  y_o = and_r;
            OP_OR:   y_o = or_r;
            OP_NOT:  y_o = not_r;
            OP_EQV:  y_o = eqv_r;
            OP_RECV: y_o = recv_r;
            OP_SEND: y_o = send_r;
            default: y_o = TV_N;
        endcase
    end

    always_comb begin
        a_r10_eval_canonical: assert (y_o.v || !y_o.d);
    end
endmodule

// File: rtl/tvl_op_unit.sv
module tvl_op_unit
    import tvl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic            a_v_i,
    input  logic            a_d_i,
    input  logic            b_v_i,
    input  logic            b_d_i,
    output logic            y_v_o,
    output logic            y_d_o
);
    tv_t         a_c, b_c, y_c;
    unit_state_t st_d, st_q;

    tvl_canon u_canon_a (.raw_v_i(a_v_i), .raw_d_i(a_d_i), .val_o(a_c));
    tvl_canon u_canon_b (.raw_v_i(b_v_i), .raw_d_i(b_d_i), .val_o(b_c));

    tvl_eval u_eval (
        .op_i (op_i),
        .a_i  (a_c),
        .b_i  (b_c),
        .y_o  (y_c)
    );

    always_comb begin
        st_d   = st_q;
        st_d.y = y_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.y <= TV_N;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_v_o = st_q.y.v;
    assign y_d_o = st_q.y.d;

    a_r10_canonical: assert property (@(posedge clk) disable iff (!rst_n)
        !y_v_o |-> !y_d_o);

    a_r6_eqv_never_n: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_EQV) |=> y_v_o);

    a_r9_unused_n: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RSV6 || op_i == OP_RSV7) |=> !y_v_o);

    a_r8_send_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SEND && !(a_v_i && a_d_i)) |=> !y_v_o);

    a_r7_recv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RECV && a_v_i && !a_d_i) |=> (y_v_o && !y_d_o));

    a_r5_not_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOT && a_v_i) |=> (y_v_o && (y_d_o == !$past(a_d_i))));

    a_r3_and_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_AND && !(a_v_i && b_v_i)) |=> !y_v_o);
endmodule

// File: tb/tvl_op_unit_tb_top.sv
module tvl_op_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] VZ = 2'b10;
    localparam logic [1:0] VO = 2'b11;
    localparam logic [1:0] VN = 2'b00;

    // rows: AND, OR, NOT, EQV, RECV, SEND; column = ia*3+ib with 0->'0', 1->'1', 2->N
    localparam logic [1:0] TT [6][9] = '{
        '{VZ, VZ, VN, VZ, VO, VN, VN, VN, VN},
        '{VZ, VO, VN, VO, VO, VN, VN, VN, VN},
        '{VO, VO, VO, VZ, VZ, VZ, VN, VN, VN},
        '{VO, VZ, VZ, VZ, VO, VZ, VZ, VZ, VO},
        '{VZ, VZ, VZ, VZ, VO, VN, VN, VN, VN},
        '{VN, VN, VN, VZ, VO, VN, VN, VN, VN}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op = 3'd0;
    logic       a_v = 1'b0, a_d = 1'b0, b_v = 1'b0, b_d = 1'b0;
    logic       y_v, y_d;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tvl_op_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op),
        .a_v_i(a_v), .a_d_i(a_d), .b_v_i(b_v), .b_d_i(b_d),
        .y_v_o(y_v), .y_d_o(y_d)
    );

    function automatic logic [1:0] enc(input int idx);
        return (idx == 0) ? VZ : (idx == 1) ? VO : VN;
    endfunction

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if ({y_v, y_d} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%b%b b=%b%b got=%b%b exp=%b",
                     req, op, a_v, a_d, b_v, b_d, y_v, y_d, exp);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [1:0] a, input logic [1:0] b);
        op = o; a_v = a[1]; a_d = a[0]; b_v = b[1]; b_d = b[0];
        @(negedge clk);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        string tag;
        // R1: reset state with a live operator on the inputs
        op = 3'd0; a_v = 1; a_d = 1; b_v = 1; b_d = 1;
        repeat (3) @(negedge clk);
        check("R1 in reset", VN);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 first result after reset", VO);

        // full truth tables
        for (int o = 0; o < 6; o++) begin
            for (int k = 0; k < 9; k++) begin
                apply(3'(o), enc(k / 3), enc(k % 3));
                case (o)
                    0: tag = "R3 AND";
                    1: tag = "R4 OR";
                    2: tag = "R5 NOT";
                    3: tag = "R6 EQV";
                    4: tag = "R7 RECV";
                    default: tag = "R8 SEND";
                endcase
                check(tag, TT[o][k]);
            end
        end

        // R9: unused codes
        for (int o = 6; o < 8; o++) begin
            for (int k = 0; k < 9; k++) begin
                apply(3'(o), enc(k / 3), enc(k % 3));
                check("R9 unused code", VN);
            end
        end

        // R11: ill-formed pair (valid=0, data=1) acts as N
        apply(3'd1, 2'b01, VO);  check("R11 OR ill-formed A", VN);
        apply(3'd0, VO, 2'b01);  check("R11 AND ill-formed B", VN);
        apply(3'd4, VO, 2'b01);  check("R11 RECV pass ill-formed", VN);
        apply(3'd5, VO, 2'b01);  check("R11 SEND pass ill-formed", VN);
        apply(3'd3, 2'b01, VN);  check("R11 EQV ill-formed equals N", VO);
        apply(3'd3, 2'b01, VZ);  check("R11 EQV ill-formed vs 0", VZ);
        apply(3'd2, 2'b01, VO);  check("R11 NOT ill-formed", VN);
        apply(3'd4, 2'b01, VO);  check("R11 RECV ill-formed enable", VN);

        // R5: B ignored by NOT, including an ill-formed B
        apply(3'd2, VZ, 2'b01);  check("R5 NOT B ill-formed", VO);

        // R2: latency and hold
        apply(3'd0, VO, VO);     check("R2 AND result", VO);
        op = 3'd1; a_v = 1; a_d = 0; b_v = 1; b_d = 0;
        #1;
        check("R2 hold before edge", VO);
        @(negedge clk);
        check("R2 next result", VZ);
        apply(3'd3, VN, VN);     check("R2 back-to-back EQV", VO);

        // R1: reset asserted mid-run
        apply(3'd4, VO, VO);     check("R7 RECV before reset", VO);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", VN);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 canonical after reset", VO);

        summary();
    end
endmodule